// File: doc/BRIEF.md
# Biased Pseudo-Random Test Vector Source

This block generates a 5-bit pseudo-random test vector on every clock in which each bit has its own fixed probability of being 1. These vectors are meant to drive a logic block under self-test. Uniformly random vectors rarely hit some faults. Tilting individual inputs towards 0 or 1 exercises wide AND-like or OR-like cones much more often.

A 16-bit maximal-length shift register with linear feedback sets the pace. It moves one step per clock while the enable input is high. Each output bit is formed from state bits that no other output uses:

- The 1/8 bit is the AND of three state bits.
- The 7/8 bit is the OR of three state bits.
- The 3/4 bit is the OR of two state bits.
- Each 1/2 bit is a single state bit.

Over one full period every nonzero state appears once. The ones count of each output is therefore exact, not approximate. A seed can be loaded at any time. An all-zero seed is replaced by a fixed nonzero constant, so the register can never lock up.

The output depends only on the current state, with no register in between. It is a plain control-style output with no handshake. A consumer that must stall simply drops the enable input, and the vector then holds.

Top module: `biased_pattern_gen`

## Requirements
- R1: While reset is active and after its release, the state is the default seed 0xACE1, and vec_out shows the weights of that state.
- R2: When seed_load is high at a clock edge, the state takes seed_value on that edge, if it is nonzero. seed_load wins over en.
- R3: When seed_load is high and seed_value is 0x0000, the state becomes 0x1D0F instead.
- R4: When en is high and seed_load is low, the state s moves to {s[14:0], s[15]^s[13]^s[12]^s[10]} at each clock edge.
- R5: When en and seed_load are both low, the state and vec_out hold their values.
- R6: Stepping from any nonzero state returns to that state after exactly 65535 steps, and never reaches zero.
- R7: vec_out[0] is the AND of state bits 1, 5 and 9, so it is 1 in 8192 of the 65535 states (about 1/8).
- R8: vec_out[1] is the OR of state bits 2 and 11, so it is 1 in 49152 of the 65535 states (about 3/4).
- R9: vec_out[2] is state bit 7 and vec_out[4] is state bit 12, so each is 1 in 32768 of the 65535 states (about 1/2).
- R10: vec_out[3] is the OR of state bits 0, 8 and 14, so it is 1 in 57344 of the 65535 states (about 7/8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance the generator one step per clock |
| seed_load | input | 1 | Load seed_value into the state (takes priority over en) |
| seed_value | input | 16 | Seed to load; zero is replaced by 0x1D0F |
| vec_out | output | 5 | Weighted test vector from the current state |

## Verification
A full uninterrupted period from a known seed is compared vector by vector against a model. The ones of each output are counted over that period. The exact counts separate an AND from an OR, two taps from three, and distinct taps from shared ones, and the return to the first vector confirms the period length. A random mix of enable and load, with a fixed seed, tells holding apart from stepping and checks that a load wins over a step. Directed zero seeds and a load asserted together with enable pin down the substitution value and the priority.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int LFSR_W = 16;
  localparam int IDX_W  = $clog2(LFSR_W);
  localparam int OUT_W  = 5;
  // Feedback taps for x^16 + x^14 + x^13 + x^11 + 1 (left-shifting form)
  localparam logic [LFSR_W-1:0] TAP_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] DEFAULT_SEED = 16'hACE1;
  localparam logic [LFSR_W-1:0] ZERO_SUB     = 16'h1D0F;
endpackage

// File: rtl/wpg_lfsr_core.sv
module wpg_lfsr_core #(
  parameter int W = 16,
  parameter logic [W-1:0] TAPS = '0,
  parameter logic [W-1:0] RESET_VAL = '1,
  parameter logic [W-1:0] ZERO_FIX = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state
);
  logic         fb;
  logic [W-1:0] load_fixed;

  assign fb         = ^(state & TAPS);
  assign load_fixed = (load_val == '0) ? ZERO_FIX : load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= RESET_VAL;
    else if (load) state <= load_fixed;
    else if (step) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/wpg_weight_cell.sv
module wpg_weight_cell #(
  parameter int W     = 16,
  parameter int IW    = 4,
  parameter int N     = 1,
  parameter bit OR_MODE = 1'b0,
  parameter logic [N*IW-1:0] PICK = '0
) (
  input  logic [W-1:0] state,
  output logic         bit_o
);
  logic [N-1:0] sel;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign sel[i] = state[PICK[i*IW +: IW]];
  end

  if (OR_MODE) begin : g_or
    assign bit_o = |sel;
  end else begin : g_and
    assign bit_o = &sel;
  end
endmodule

// File: rtl/biased_pattern_gen.sv
module biased_pattern_gen
  import wpg_pkg::*;
#(
  parameter logic [LFSR_W-1:0] INIT_SEED = DEFAULT_SEED,
  parameter logic [LFSR_W-1:0] ZERO_SEED = ZERO_SUB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_value,
  output logic [OUT_W-1:0]  vec_out
);
  logic [LFSR_W-1:0] state_q;

  wpg_lfsr_core #(
    .W(LFSR_W), .TAPS(TAP_MASK), .RESET_VAL(INIT_SEED), .ZERO_FIX(ZERO_SEED)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .step(en), .load(seed_load),
    .load_val(seed_value), .state(state_q)
  );

  // 1/8 : AND of bits 1,5,9
  wpg_weight_cell #(.W(LFSR_W), .IW(IDX_W), .N(3), .OR_MODE(1'b0),
    .PICK({4'd9, 4'd5, 4'd1})) u_w0 (.state(state_q), .bit_o(vec_out[0]));
  // 3/4 : OR of bits 2,11
  wpg_weight_cell #(.W(LFSR_W), .IW(IDX_W), .N(2), .OR_MODE(1'b1),
    .PICK({4'd11, 4'd2})) u_w1 (.state(state_q), .bit_o(vec_out[1]));
  // 1/2 : bit 7
  wpg_weight_cell #(.W(LFSR_W), .IW(IDX_W), .N(1), .OR_MODE(1'b1),
    .PICK(4'd7)) u_w2 (.state(state_q), .bit_o(vec_out[2]));
  // 7/8 : OR of bits 0,8,14
  wpg_weight_cell #(.W(LFSR_W), .IW(IDX_W), .N(3), .OR_MODE(1'b1),
    .PICK({4'd14, 4'd8, 4'd0})) u_w3 (.state(state_q), .bit_o(vec_out[3]));
  // 1/2 : bit 12
  wpg_weight_cell #(.W(LFSR_W), .IW(IDX_W), .N(1), .OR_MODE(1'b1),
    .PICK(4'd12)) u_w4 (.state(state_q), .bit_o(vec_out[4]));
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int W = 16,
  parameter logic [W-1:0] ZERO_SEED = 16'h1D0F
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         seed_load,
  input logic [W-1:0] seed_value,
  input logic [W-1:0] state,
  input logic [4:0]   vec_out
);
  // R2
  seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_value != '0) |=> state == $past(seed_value));

  // R3
  zero_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed_value == '0) |=> state == ZERO_SEED);

  // R4
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !seed_load) |=> state[W-1:1] == $past(state[W-2:0]));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !seed_load) |=> ($stable(state) && $stable(vec_out)));

  // R6
  never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

bind biased_pattern_gen wpg_checker #(.W(wpg_pkg::LFSR_W), .ZERO_SEED(ZERO_SEED)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
  .seed_value(seed_value), .state(state_q), .vec_out(vec_out)
);

// File: tb/biased_pattern_gen_test.sv
`timescale 1ns/1ps
module biased_pattern_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed_value = '0;
  logic [4:0]  vec_out;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  logic [15:0] model;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  biased_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
    .seed_value(seed_value), .vec_out(vec_out)
  );

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [4:0] weights(input logic [15:0] s);
    logic [4:0] v;
    v[0] = s[1] & s[5] & s[9];
    v[1] = s[2] | s[11];
    v[2] = s[7];
    v[3] = s[0] | s[8] | s[14];
    v[4] = s[12];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive, update model, compare vector
  task automatic cycle(input bit e, input bit l, input logic [15:0] s, input string req);
    en = e; seed_load = l; seed_value = s;
    @(posedge clk); #1;
    if (l) model = (s == 16'h0) ? 16'h1D0F : s;
    else if (e) model = nxt(model);
    en = 1'b0; seed_load = 1'b0;
    check(vec_out == weights(model), req, vec_out, weights(model));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned ones [5];
    logic [4:0] first_vec;
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    check(vec_out == weights(16'hACE1), "R1 reset", vec_out, weights(16'hACE1));
    rst_n = 1'b1;
    model = 16'hACE1;
    cycle(1'b0, 1'b0, 16'h0, "R1 post-reset hold");

    // R5 hold with enable low
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, 16'hFFFF, "R5 hold");
    // R4 steps
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, 16'h0, "R4 step");
    // R2 load with enable high: load wins
    cycle(1'b1, 1'b1, 16'h8001, "R2 load over enable");
    cycle(1'b0, 1'b1, 16'h0002, "R2 load");
    // R3 zero seed substitution
    cycle(1'b1, 1'b1, 16'h0000, "R3 zero seed");
    cycle(1'b1, 1'b0, 16'h0, "R3 step after zero seed");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit e, l;
      logic [15:0] s;
      e = ($urandom % 2) == 0;
      l = ($urandom % 16) == 0;
      s = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
      cycle(e, l, s, l ? (s == 0 ? "R3 random zero" : "R2 random load")
                        : (e ? "R4 random step" : "R5 random hold"));
    end

    // full period from a known seed
    cycle(1'b0, 1'b1, 16'hACE1, "R2 period seed");
    first_vec = vec_out;
    for (int b = 0; b < 5; b++) ones[b] = 0;
    for (int i = 0; i < 65535; i++) begin
      for (int b = 0; b < 5; b++) ones[b] += vec_out[b];
      cycle(1'b1, 1'b0, 16'h0, "R6 period sequence");
    end
    check(vec_out == first_vec, "R6 period length", vec_out, first_vec);
    check(ones[0] == 8192,  "R7 bit0 ones",  ones[0], 8192);
    check(ones[1] == 49152, "R8 bit1 ones",  ones[1], 49152);
    check(ones[2] == 32768, "R9 bit2 ones",  ones[2], 32768);
    check(ones[4] == 32768, "R9 bit4 ones",  ones[4], 32768);
    check(ones[3] == 57344, "R10 bit3 ones", ones[3], 57344);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule